// File: doc/BRIEF.md
# Multichannel Shared-Coefficient FIR Engine

This block is a fixed-point filter coprocessor. It keeps a short sample history for each of several channels in an internal data memory. It holds coefficient sets in an internal coefficient memory. For every accepted input sample it forms one dot product between that channel's history and a coefficient set, and it places the saturated result in a single output register. Samples for all channels enter through one input register, one at a time, and are dealt to the channels in rotation. Results therefore leave in channel order.

A host sets up the engine through a small word-addressed register bus while the engine is disabled. The host loads both memories, writes the tap count, channel count and the two base addresses, and then enables the engine through the control word. When one coefficient set is shared by every channel, the block can multiply two matrices. The host loads the rows of the left matrix as channel histories, with the elements of each row fed in reverse order. It loads the columns of the right matrix as consecutive coefficient sets. Moving the coefficient base from one set to the next then yields the product one column at a time.

Top module: `mcfir_engine`

## Requirements
- R1: After reset the control word (address 0) reads 0x4000: only the input-empty flag (bit 14) is set. Every other register reads 0 and `irq` is low.
- R2: Addresses 1 to 4 hold tap count minus one, channel count minus one, data base and coefficient base. Writes to them are ignored while the enable bit (control bit 0) is set.
- R3: An accepted sample shifts the current channel's history by one place, with the newest sample at position 0. The result is ((sum over k of history[k]·coef[k]) arithmetically shifted right by DW−1), clipped to the signed DW-bit range.
- R4: Position k of channel c lives at data address dbase + c·L + k, where L is the tap count. Coefficient k is read at cbase + k when sharing (control bit 8) is set, and at cbase + c·L + k otherwise. All addresses wrap modulo the memory depth.
- R5: With multichannel mode (control bit 6) set, successive samples go to channels 0, 1, …, N−1 and then back to 0. With it clear, every sample goes to channel 0.
- R6: Samples are processed only when bit 0 = 1, bit 1 (IIR select) = 0 and bits 5:4 (FIR mode) = 00. In any other setting no result is produced.
- R7: A write to the input register (address 5) is accepted only while the engine is enabled and the input-empty flag is set. Acceptance clears the flag. Any other such write is dropped. Disabling the engine empties the input buffer.
- R8: A finished result appears at address 6 and sets the output-full flag (bit 15). Reading address 6 clears the flag. No new computation starts while the flag is set.
- R9: A clipped result sets the saturation flag (bit 12). The flag stays set until a control write with bit 12 = 1 clears it.
- R10: `irq` = (bit 10 AND input-empty) OR (bit 11 AND output-full).
- R11: Each 0-to-1 transition of the enable bit restarts the channel rotation at channel 0.
- R12: A write to address 7 loads one memory word. Bit 31 selects the coefficient memory (1) or the data memory (0), bits 23:16 give the address and bits 15:0 give the value. The write is ignored while the engine is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; a read of address 6 clears the output-full flag |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request built from the enabled buffer flags |

## Verification
The single-channel sequence feeds signed samples of mixed sign through a four-tap filter. It tells a correct history shift apart from a reversed or stale one. The two-channel matrix run feeds reversed rows and moves the coefficient base between columns. It separates correct channel interleaving, shared coefficient addressing and output ordering from swapped channels or wrong bases. It is checked against a plain matrix product. The per-channel coefficient run and the restart run use a different coefficient set per channel, so a channel pointer that fails to advance or to reset gives a visibly wrong value. Full-scale positive and negative pairs force clipping in both directions and show whether the flag is sticky and whether it clears.

// File: rtl/mcfir_pkg.sv
// Shared constants for the multichannel FIR engine: register word
// addresses, control-word bit positions and the sequencer state type.
package mcfir_pkg;
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_TAPS = 3'd1;
    localparam logic [2:0] A_CHNS = 3'd2;
    localparam logic [2:0] A_DBAS = 3'd3;
    localparam logic [2:0] A_CBAS = 3'd4;
    localparam logic [2:0] A_SMPL = 3'd5;
    localparam logic [2:0] A_RSLT = 3'd6;
    localparam logic [2:0] A_MEML = 3'd7;

    localparam int B_EN     = 0;
    localparam int B_IIR    = 1;
    localparam int B_MODE   = 4;
    localparam int B_MULTI  = 6;
    localparam int B_SHARE  = 8;
    localparam int B_IE_IN  = 10;
    localparam int B_IE_OUT = 11;
    localparam int B_SAT    = 12;
    localparam int B_EMPTY  = 14;
    localparam int B_FULL   = 15;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_MAC   = 2'd2,
        S_DONE  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/mcfir_mac.sv
// Multiply-accumulate unit with output scaling and clipping.
// Assumes: clr and en are never high together; the accumulator is wide
// enough for MAX_TAPS full-scale products, so it never wraps.
module mcfir_mac #(
    parameter int DW   = 16,
    parameter int ACCW = 35
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] c,
    output logic        [DW-1:0] result,
    output logic                 clipped
);
    localparam int PW = 2 * DW;

    logic signed [ACCW-1:0] acc;
    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] scaled;
    logic                   top_ones;
    logic                   top_zeros;

    assign prod = x * c;

    // Accumulate one product per enabled cycle, restart on clr.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else if (en)  acc <= acc + {{(ACCW-PW){prod[PW-1]}}, prod};
    end

    // Scale to output format and clip to the signed DW-bit range.
    always_comb begin
        scaled    = acc >>> (DW - 1);
        top_ones  = &scaled[ACCW-1:DW-1];
        top_zeros = ~|scaled[ACCW-1:DW-1];
        clipped   = !(top_ones || top_zeros);
        if (!clipped)            result = scaled[DW-1:0];
        else if (scaled[ACCW-1]) result = {1'b1, {(DW-1){1'b0}}};
        else                     result = {1'b0, {(DW-1){1'b1}}};
    end
endmodule

// File: rtl/mcfir_cfg.sv
// Register file of the FIR engine: control word, configuration, the
// one-deep input and output buffers, sticky saturation and irq.
// Assumes: reads are combinational; one bus access per cycle; the core
// only delivers a result while the output buffer is empty.
module mcfir_cfg
    import mcfir_pkg::*;
#(
    parameter int DW  = 16,
    parameter int TW  = 3,
    parameter int CW  = 2,
    parameter int DAW = 5,
    parameter int CAW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic           bus_re,
    input  logic [2:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           irq,
    output logic           en,
    output logic           en_rise,
    output logic           run_ok,
    output logic           multi,
    output logic           shared,
    output logic [TW-1:0]  tap_m1,
    output logic [CW-1:0]  ch_m1,
    output logic [DAW-1:0] dbase,
    output logic [CAW-1:0] cbase,
    output logic           in_full,
    output logic [DW-1:0]  in_sample,
    output logic           out_full,
    output logic [DW-1:0]  result_q,
    output logic           sat_q,
    output logic           mem_we,
    output logic           mem_sel,
    output logic [7:0]     mem_addr,
    output logic [DW-1:0]  mem_data,
    input  logic           take,
    input  logic           res_valid,
    input  logic [DW-1:0]  res_data,
    input  logic           res_sat
);
    logic       iir;
    logic [1:0] mode;
    logic       ie_in;
    logic       ie_out;
    logic       wr_ctrl;
    logic       rd_res;

    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign rd_res  = bus_re && (bus_addr == A_RSLT);
    assign en_rise = wr_ctrl && bus_wdata[B_EN] && !en;
    assign run_ok  = en && !iir && (mode == 2'b00);
    assign irq     = (ie_in && !in_full) || (ie_out && out_full);

    assign mem_we   = bus_we && (bus_addr == A_MEML) && !en;
    assign mem_sel  = bus_wdata[31];
    assign mem_addr = bus_wdata[23:16];
    assign mem_data = bus_wdata[DW-1:0];

    // Control word fields and the sticky saturation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; iir <= 1'b0; mode <= 2'b00; multi <= 1'b0;
            shared <= 1'b0; ie_in <= 1'b0; ie_out <= 1'b0; sat_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en     <= bus_wdata[B_EN];
                iir    <= bus_wdata[B_IIR];
                mode   <= bus_wdata[B_MODE+1:B_MODE];
                multi  <= bus_wdata[B_MULTI];
                shared <= bus_wdata[B_SHARE];
                ie_in  <= bus_wdata[B_IE_IN];
                ie_out <= bus_wdata[B_IE_OUT];
                if (bus_wdata[B_SAT]) sat_q <= 1'b0;
            end
            if (res_valid && res_sat) sat_q <= 1'b1;
        end
    end

    // Configuration registers, writable only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_m1 <= '0; ch_m1 <= '0; dbase <= '0; cbase <= '0;
        end else if (bus_we && !en) begin
            case (bus_addr)
                A_TAPS:  tap_m1 <= bus_wdata[TW-1:0];
                A_CHNS:  ch_m1  <= bus_wdata[CW-1:0];
                A_DBAS:  dbase  <= bus_wdata[DAW-1:0];
                A_CBAS:  cbase  <= bus_wdata[CAW-1:0];
                default: ;
            endcase
        end
    end

    // One-deep input buffer: filled by the bus, drained by the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_full <= 1'b0; in_sample <= '0;
        end else if (!en) begin
            in_full <= 1'b0;
        end else if (bus_we && (bus_addr == A_SMPL) && !in_full) begin
            in_full   <= 1'b1;
            in_sample <= bus_wdata[DW-1:0];
        end else if (take) begin
            in_full <= 1'b0;
        end
    end

    // One-deep output buffer: filled by the core, drained by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_full <= 1'b0; result_q <= '0;
        end else begin
            if (rd_res) out_full <= 1'b0;
            if (res_valid) begin
                out_full <= 1'b1;
                result_q <= res_data;
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = {16'd0, out_full, !in_full, 1'b0, sat_q,
                                 ie_out, ie_in, 1'b0, shared, 1'b0, multi,
                                 mode, 2'b00, iir, en};
            A_TAPS: bus_rdata = 32'(tap_m1);
            A_CHNS: bus_rdata = 32'(ch_m1);
            A_DBAS: bus_rdata = 32'(dbase);
            A_CBAS: bus_rdata = 32'(cbase);
            A_RSLT: bus_rdata = {{(32-DW){result_q[DW-1]}}, result_q};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mcfir_core.sv
// Sequencer and memories of the FIR engine. Per sample: take it from the
// input buffer, shift the channel history in data memory (one word per
// cycle, newest at position 0), run L multiply-accumulate cycles, then
// deliver the result and advance the channel pointer.
// Assumes: memory loads arrive only while disabled; DAW and CAW <= 8.
module mcfir_core
    import mcfir_pkg::*;
#(
    parameter int DW   = 16,
    parameter int TW   = 3,
    parameter int CW   = 2,
    parameter int DAW  = 5,
    parameter int CAW  = 5,
    parameter int ACCW = 35
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_ok,
    input  logic           en_rise,
    input  logic           multi,
    input  logic           shared,
    input  logic [TW-1:0]  tap_m1,
    input  logic [CW-1:0]  ch_m1,
    input  logic [DAW-1:0] dbase,
    input  logic [CAW-1:0] cbase,
    input  logic           in_full,
    input  logic [DW-1:0]  in_sample,
    input  logic           out_full,
    input  logic           mem_we,
    input  logic           mem_sel,
    input  logic [7:0]     mem_addr,
    input  logic [DW-1:0]  mem_data,
    output logic           take,
    output logic           res_valid,
    output logic [DW-1:0]  res_data,
    output logic           res_sat,
    output logic [CW-1:0]  ch_ptr
);
    localparam int DWORDS = 1 << DAW;
    localparam int CWORDS = 1 << CAW;

    logic [DW-1:0]  dmem [DWORDS];
    logic [DW-1:0]  cmem [CWORDS];
    seq_state_t     state;
    logic [TW-1:0]  k;
    logic [DW-1:0]  samp_q;
    logic [31:0]    ch_off;
    logic [DAW-1:0] d_win, d_at, d_prev;
    logic [CAW-1:0] c_win, c_at;

    assign ch_off = 32'(ch_ptr) * (32'(tap_m1) + 32'd1);
    assign d_win  = dbase + ch_off[DAW-1:0];
    assign d_at   = d_win + DAW'(k);
    assign d_prev = d_at - DAW'(1);
    assign c_win  = cbase + (shared ? '0 : ch_off[CAW-1:0]);
    assign c_at   = c_win + CAW'(k);

    assign take      = (state == S_IDLE) && run_ok && in_full && !out_full;
    assign res_valid = (state == S_DONE) && run_ok;

    // Data memory: host loads while disabled, history shift while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DWORDS; i++) dmem[i] <= '0;
        end else if (mem_we && !mem_sel) begin
            dmem[mem_addr[DAW-1:0]] <= mem_data;
        end else if (state == S_SHIFT && run_ok) begin
            if (k == '0) dmem[d_at] <= samp_q;
            else         dmem[d_at] <= dmem[d_prev];
        end
    end

    // Coefficient memory: written only by host loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CWORDS; i++) cmem[i] <= '0;
        end else if (mem_we && mem_sel) begin
            cmem[mem_addr[CAW-1:0]] <= mem_data;
        end
    end

    // Sequencer and channel rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; k <= '0; samp_q <= '0; ch_ptr <= '0;
        end else begin
            if (en_rise) ch_ptr <= '0;
            if (!run_ok) begin
                state <= S_IDLE;
            end else begin
                case (state)
                    S_IDLE: if (take) begin
                        samp_q <= in_sample;
                        k      <= tap_m1;
                        state  <= S_SHIFT;
                    end
                    S_SHIFT: if (k == '0) state <= S_MAC;
                             else         k <= k - 1'b1;
                    S_MAC:   if (k == tap_m1) state <= S_DONE;
                             else             k <= k + 1'b1;
                    S_DONE: begin
                        state  <= S_IDLE;
                        ch_ptr <= (!multi || ch_ptr == ch_m1) ? '0 : ch_ptr + 1'b1;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    mcfir_mac #(.DW(DW), .ACCW(ACCW)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (take),
        .en      ((state == S_MAC) && run_ok),
        .x       (dmem[d_at]),
        .c       (cmem[c_at]),
        .result  (res_data),
        .clipped (res_sat)
    );
endmodule

// File: rtl/mcfir_engine.sv
// Top of the multichannel shared-coefficient FIR engine: register file
// plus sequencer/memories. Assumes a single clock and synchronous reset.
module mcfir_engine #(
    parameter int DW       = 16,
    parameter int MAX_TAPS = 8,
    parameter int MAX_CH   = 4,
    parameter int DWORDS   = 32,
    parameter int CWORDS   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int TW   = $clog2(MAX_TAPS);
    localparam int CW   = $clog2(MAX_CH);
    localparam int DAW  = $clog2(DWORDS);
    localparam int CAW  = $clog2(CWORDS);
    localparam int ACCW = 2 * DW + TW;

    logic           ctrl_en, en_rise, run_ok, multi, shared;
    logic [TW-1:0]  tap_m1;
    logic [CW-1:0]  ch_m1;
    logic [DAW-1:0] dbase;
    logic [CAW-1:0] cbase;
    logic           in_full, out_full, sat_flag;
    logic [DW-1:0]  in_sample, result_q;
    logic           mem_we, mem_sel;
    logic [7:0]     mem_addr;
    logic [DW-1:0]  mem_data;
    logic           take, res_valid, res_sat;
    logic [DW-1:0]  res_data;
    logic [CW-1:0]  ch_ptr;

    mcfir_cfg #(.DW(DW), .TW(TW), .CW(CW), .DAW(DAW), .CAW(CAW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .en(ctrl_en), .en_rise(en_rise), .run_ok(run_ok),
        .multi(multi), .shared(shared), .tap_m1(tap_m1), .ch_m1(ch_m1),
        .dbase(dbase), .cbase(cbase), .in_full(in_full),
        .in_sample(in_sample), .out_full(out_full), .result_q(result_q),
        .sat_q(sat_flag), .mem_we(mem_we), .mem_sel(mem_sel),
        .mem_addr(mem_addr), .mem_data(mem_data), .take(take),
        .res_valid(res_valid), .res_data(res_data), .res_sat(res_sat)
    );

    mcfir_core #(.DW(DW), .TW(TW), .CW(CW), .DAW(DAW), .CAW(CAW),
                 .ACCW(ACCW)) u_core (
        .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .en_rise(en_rise),
        .multi(multi), .shared(shared), .tap_m1(tap_m1), .ch_m1(ch_m1),
        .dbase(dbase), .cbase(cbase), .in_full(in_full),
        .in_sample(in_sample), .out_full(out_full), .mem_we(mem_we),
        .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_data(mem_data),
        .take(take), .res_valid(res_valid), .res_data(res_data),
        .res_sat(res_sat), .ch_ptr(ch_ptr)
    );
endmodule

// File: rtl/mcfir_checker.sv
// Temporal checks on the FIR engine, bound to every instance of the top.
module mcfir_checker
    import mcfir_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 3,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic          bus_re,
    input logic [2:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          ctrl_en,
    input logic [TW-1:0] tap_m1,
    input logic          out_full,
    input logic [DW-1:0] result_q,
    input logic          sat_flag,
    input logic [CW-1:0] ch_ptr,
    input logic [CW-1:0] ch_m1,
    input logic          take,
    input logic          in_full
);
    // R8: an unread result is neither replaced nor dropped.
    p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_full && !(bus_re && bus_addr == A_RSLT) |=> out_full && $stable(result_q));

    // R2: configuration is frozen while enabled.
    p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en && bus_we && bus_addr == A_TAPS |=> $stable(tap_m1));

    // R9: saturation flag holds until explicitly cleared.
    p_sat_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag && !(bus_we && bus_addr == A_CTRL && bus_wdata[B_SAT]) |=> sat_flag);

    // R11: enabling starts the rotation at channel 0.
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_en) |-> ch_ptr == '0);

    // R5: channel pointer stays inside the configured channel count.
    p_ch_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en |-> ch_ptr <= ch_m1);

    // R7: a consumed sample leaves the input buffer empty.
    p_take_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !in_full);
endmodule

bind mcfir_engine mcfir_checker #(.DW(DW), .TW(TW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctrl_en(ctrl_en),
    .tap_m1(tap_m1), .out_full(out_full), .result_q(result_q),
    .sat_flag(sat_flag), .ch_ptr(ch_ptr), .ch_m1(ch_m1), .take(take),
    .in_full(in_full)
);

// File: tb/mcfir_engine_bench.sv
// Directed bench for mcfir_engine: one task per scenario, each checking
// its own results against a reference model written from the requirements.
module mcfir_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    // Reference state
    int m_d[32];
    int m_c[32];
    int m_taps = 1, m_db = 0, m_cb = 0, m_nch = 1, m_ptr = 0;
    bit m_shared = 0, m_multi = 0;

    always #4 clk = ~clk;

    mcfir_engine u_mcfir_engine (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = 32'(d); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        @(negedge clk);
        bus_addr = 3'(a); bus_re = 1'b1;
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_full(string req);
        int v;
        bit got = 0;
        for (int i = 0; i < 100 && !got; i++) begin
            rd(0, v);
            if (v[15]) got = 1;
        end
        chk({req, " result ready"}, got, 1);
    endtask

    function automatic int model_push(int s);
        int base, cw;
        longint acc, q;
        base = m_db + m_ptr * m_taps;
        for (int k = m_taps - 1; k > 0; k--)
            m_d[(base + k) % 32] = m_d[(base + k - 1) % 32];
        m_d[base % 32] = s;
        cw = m_cb + (m_shared ? 0 : m_ptr * m_taps);
        acc = 0;
        for (int k = 0; k < m_taps; k++)
            acc += longint'(m_d[(base + k) % 32]) * longint'(m_c[(cw + k) % 32]);
        q = acc >>> 15;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        m_ptr = (!m_multi || m_ptr == m_nch - 1) ? 0 : m_ptr + 1;
        return int'(q);
    endfunction

    task automatic push_chk(string req, int s);
        int exp, got;
        exp = model_push(s);
        wr(5, s & 32'hFFFF);
        wait_full(req);
        rd(6, got);
        chk(req, got, exp);
    endtask

    task automatic load(bit sel, int a, int v);
        wr(6'd0 + 7, (int'(sel) << 31) | (a << 16) | (v & 32'hFFFF));
        if (sel) m_c[a] = v; else m_d[a] = v;
    endtask

    task automatic setup(int taps, int nch, int db, int cb);
        wr(0, 0);
        wr(1, taps - 1); wr(2, nch - 1); wr(3, db); wr(4, cb);
        m_taps = taps; m_nch = nch; m_db = db; m_cb = cb;
    endtask

    task automatic enable(int ctl);
        wr(0, ctl);
        m_shared = ctl[8]; m_multi = ctl[6]; m_ptr = 0;
    endtask

    task automatic t_reset;
        int v;
        rd(0, v); chk("R1 ctrl", v, 32'h4000);
        rd(1, v); chk("R1 taps", v, 0);
        rd(6, v); chk("R1 result", v, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_single;
        int smp[6] = '{1000, -2000, 3000, 500, 7000, -12000};
        int cf[4] = '{8192, -4096, 16384, 2048};
        setup(4, 1, 0, 0);
        for (int i = 0; i < 4; i++) load(1, i, cf[i]);
        enable(32'h101);
        foreach (smp[i]) push_chk("R3 single-channel shift", smp[i]);
    endtask

    task automatic t_matrix;
        int A[2][3] = '{'{6000, -3000, 9000}, '{12000, 4000, -7000}};
        int B[3][4] = '{'{10000, -5000, 20000, 3000},
                        '{-8000, 15000, 2500, -12000},
                        '{7000, 6000, -9000, 11000}};
        int got;
        longint dot;
        setup(3, 2, 16, 0);
        for (int col = 0; col < 4; col++)
            for (int j = 0; j < 3; j++) load(1, col * 3 + j, B[j][col]);
        for (int col = 0; col < 4; col++) begin
            wr(0, 0); wr(4, col * 3); m_cb = col * 3;
            enable(32'h141);
            for (int j = 2; j >= 0; j--)
                for (int r = 0; r < 2; r++) begin
                    int exp;
                    exp = model_push(A[r][j]);
                    wr(5, A[r][j] & 32'hFFFF);
                    wait_full("R5 interleave");
                    rd(6, got);
                    chk("R4 R5 shared interleaved", got, exp);
                    if (j == 0) begin
                        dot = 0;
                        for (int t = 0; t < 3; t++) dot += longint'(A[r][t]) * B[t][col];
                        chk("R4 matrix element", got, dot >>> 15);
                    end
                end
        end
    endtask

    task automatic t_percoef;
        int cf[6] = '{16384, -16384, 8192, 32767, -32768, 4096};
        setup(2, 3, 8, 20);
        for (int i = 0; i < 6; i++) load(1, 20 + i, cf[i]);
        enable(32'h041);
        for (int i = 0; i < 6; i++) push_chk("R4 per-channel coefficients", 1500 * (i + 1) - 4000);
    endtask

    task automatic t_sat;
        int v;
        setup(2, 1, 28, 28);
        load(1, 28, 32767); load(1, 29, 32767);
        enable(32'h101);
        push_chk("R9 positive clip", 32767);
        push_chk("R9 positive clip", 32767);
        rd(0, v); chk("R9 flag set", v[12], 1);
        push_chk("R9 unclipped", -100);
        rd(0, v); chk("R9 flag sticky", v[12], 1);
        push_chk("R9 negative clip", -32768);
        wr(0, 32'h1101);
        rd(0, v); chk("R9 flag cleared", v[12], 0);
    endtask

    task automatic t_backpressure;
        int v, e1, e2;
        setup(2, 1, 26, 26);
        load(1, 26, 16384); load(1, 27, 8192);
        enable(32'h101);
        e1 = model_push(3000);
        wr(5, 3000);
        wait_full("R8 first");
        e2 = model_push(-5000);
        wr(5, -5000 & 32'hFFFF);
        repeat (40) @(negedge clk);
        rd(0, v); chk("R7 second sample held", v[14], 0);
        wr(5, 9999);
        rd(6, v); chk("R8 no overwrite while full", v, e1);
        wait_full("R8 second");
        rd(6, v); chk("R7 R8 held sample processed", v, e2);
        rd(0, v); chk("R7 dropped write leaves buffer empty", v[14], 1);
        push_chk("R7 dropped sample absent from history", 700);
    endtask

    task automatic t_irq;
        int v, e;
        enable(32'h101);
        wr(0, 32'h901);
        chk("R10 irq low with empty output", irq, 0);
        e = model_push(2000);
        wr(5, 2000);
        wait_full("R10");
        @(negedge clk); chk("R10 irq on full", irq, 1);
        rd(6, v); chk("R10 result", v, e);
        @(negedge clk); chk("R10 irq after read", irq, 0);
        wr(0, 32'h501);
        @(negedge clk); chk("R10 irq on input empty", irq, 1);
    endtask

    task automatic t_lock;
        int v;
        wr(1, 5);
        rd(1, v); chk("R2 taps locked", v, 1);
        wr(7, (1 << 31) | (26 << 16) | 100);
        push_chk("R12 load ignored while enabled", -1234);
        wr(0, 0);
        load(1, 26, -16384);
        enable(32'h101);
        push_chk("R12 load while disabled", 4321);
    endtask

    task automatic t_gate;
        int v;
        wr(0, 32'h103);
        wr(5, 1000);
        repeat (30) @(negedge clk);
        rd(0, v); chk("R6 IIR select blocks", v[15], 0);
        chk("R7 sample still held", v[14], 0);
        wr(0, 0);
        rd(0, v); chk("R7 disable empties", v[14], 1);
        wr(0, 32'h111);
        wr(5, 1000);
        repeat (30) @(negedge clk);
        rd(0, v); chk("R6 nonzero mode blocks", v[15], 0);
        wr(0, 0);
    endtask

    task automatic t_restart;
        setup(1, 2, 30, 30);
        load(1, 30, 16384); load(1, 31, -8192);
        enable(32'h041);
        push_chk("R11 first channel 0", 4000);
        wr(0, 0);
        enable(32'h041);
        push_chk("R11 restart at channel 0", 6000);
        push_chk("R11 then channel 1", 6000);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_d[i] = 0; m_c[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_matrix();
        t_percoef();
        t_sat();
        t_backpressure();
        t_irq();
        t_lock();
        t_gate();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule